// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the write side of a NOR-style parallel flash model. It watches bus write cycles and walks the multi-cycle command protocol: the two-write unlock handshake, the command byte, and the data or confirm cycle that follows. It turns accepted commands into one-cycle request strobes toward a separate byte array: program a location, erase one sector, or erase the whole chip. It also tracks the identification mode, the query mode and an unlock-bypass mode in which repeated programs skip the handshake. The read path and the array itself live elsewhere and follow the `read_mode` and `status_byte` outputs.

Command matching uses the offset of the write within its sector, scaled to bus words according to the configured bus width. Erase requests start a busy period counted in clock cycles. Writes are ignored during that period, and at its end status bit 7 toggles. A read-only input masks every array request but leaves the protocol and status untouched. The array is expected to merge program data by AND, so a program can only clear bits. Erased bytes read back as 0xFF.

Top module: `nor_cmd_seq`

States and transitions:
- S_IDLE: 0xAA at offset A goes to S_KEY2. 0x98 at offset 0x55 goes to S_QUERY.
- S_KEY2: 0x55 at offset B goes to S_DECODE.
- S_DECODE:
  - 0xA0 goes to S_PROGRAM.
  - 0x80 goes to S_EKEY1.
  - 0x90 goes to S_IDMODE.
  - 0x20 sets bypass and stays in S_DECODE.
- S_PROGRAM: any write issues a program. The next state is S_DECODE if bypass is set, otherwise S_IDLE.
- S_EKEY1: 0xAA at offset A goes to S_EKEY2. 0x98 at offset 0x55 goes to S_QUERY.
- S_EKEY2: 0x55 at offset B goes to S_ESELECT.
- S_ESELECT: 0x30 (sector erase), or 0x10 at offset A (chip erase), goes to S_EBUSY.
- S_EBUSY: on timer expiry, goes to S_DECODE if bypass is set, otherwise S_IDLE.
- S_IDMODE: 0x98 at offset 0x55 goes to S_QUERY.
- S_QUERY: any write goes to S_IDLE.

Every write not listed above goes to S_IDLE and clears bypass. The 0xF0 reset, defined in R9, takes precedence.

## Requirements
- R1: After reset the outputs are as follows: `cmd_state` is S_IDLE, `read_mode` is array, bypass is clear, `status_byte` is 0x00, and no strobe is active.
- R2: Command addresses are compared on the in-sector offset `wr_addr[SECT_W-1:0]`. The offset is shifted right by 0, 1 or 2 for `bus_width` code 0 (1 byte), 1 (2 bytes) or 2 (4 bytes); code 3 acts as code 0. Sector bits above the offset are ignored. With the default offsets A=0x555 and B=0x2AA, a 2-byte bus therefore unlocks at byte addresses 0xAAA and 0x554.
- R3: In S_IDLE, 0x98 at word offset 0x55 enters S_QUERY, and 0xAA at offset A enters S_KEY2. Any other write stays in S_IDLE. The command byte is `wr_data[7:0]`.
- R4: In S_KEY2 only 0x55 at offset B advances to S_DECODE. In S_DECODE without bypass, the write must be at offset A and carry 0x20, 0x80, 0x90 or 0xA0. Any other write returns to S_IDLE.
- R5: The write after 0xA0 issues a one-cycle `prog_stb` in the following cycle. The strobe carries the address, the full data word and the lane count (1, 2 or 4). `status_byte` becomes {~wr_data[7], 7'h7F}, and the sequencer leaves S_PROGRAM.
- R6: Command 0x20 sets `bypass_active` and parks in S_DECODE. In this mode a command is accepted at any address, and a finished program returns to S_DECODE.
- R7: The sequence 0x80, then 0xAA at A, then 0x55 at B, then a final write selects the erase. A final 0x30 at any address strobes `sect_erase_stb` with `erase_addr` set to the sector base. A final 0x10 at offset A strobes `chip_erase_stb`; 0x10 elsewhere returns to S_IDLE. An accepted erase clears `status_byte` to 0x00.
- R8: An accepted erase holds S_EBUSY for exactly SECT_ERASE_CYC or CHIP_ERASE_CYC cycles. Writes other than 0xF0 are ignored during this time. At expiry, status bit 7 toggles and the state becomes S_IDLE, or S_DECODE if bypass is set.
- R9: A write of 0xF0 in any state except S_PROGRAM returns to S_IDLE and clears bypass. In S_EBUSY it aborts the wait with no status toggle. In S_PROGRAM, 0xF0 is programmed as data.
- R10: In S_IDMODE, 0x98 at offset 0x55 enters S_QUERY and keeps bypass. Any other write, including 0x00 with bypass set, returns to S_IDLE and clears bypass.
- R11: Any write in S_QUERY returns to S_IDLE and clears bypass.
- R12: While `read_only` is high, no program or erase strobe is issued. State transitions and `status_byte` behave as they would with `read_only` low.
- R13: `cmd_state` codes are: S_IDLE=0, S_KEY2=1, S_DECODE=2, S_PROGRAM=3, S_EKEY1=4, S_EKEY2=5, S_ESELECT=6, S_EBUSY=7, S_IDMODE=8, S_QUERY=9. `read_mode` codes are: 1 in S_IDMODE, 2 in S_QUERY, 3 in S_PROGRAM and S_EBUSY, and 0 otherwise. At most one strobe is active per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data; the command byte is bits 7:0 |
| bus_width | input | 2 | Bus width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| read_only | input | 1 | Masks all array requests |
| cmd_state | output | 4 | Current sequencer state code |
| read_mode | output | 2 | Source for reads: array, ident, query or status |
| bypass_active | output | 1 | Unlock-bypass mode flag |
| status_byte | output | 8 | Status value for the read path |
| prog_stb | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program byte address |
| prog_data | output | 32 | Program data, to be ANDed into the cells |
| prog_bytes | output | 3 | Number of bytes to program |
| sect_erase_stb | output | 1 | One-cycle sector erase request |
| chip_erase_stb | output | 1 | One-cycle chip erase request |
| erase_addr | output | ADDR_W | Sector base address of the erase |

## Verification
The bench builds the block with a 1 MiB space of 64 KiB sectors and the default unlock offsets. This lets the same command sequences run on all three bus widths, and in more than one sector. The busy periods are shortened to 40 cycles for a sector and 100 cycles for the chip. With those values the exact expiry cycle, the status toggle, the return to bypass decode, and the abort by 0xF0 are all observed within a short run.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_KEY2    = 4'd1,
        S_DECODE  = 4'd2,
        S_PROGRAM = 4'd3,
        S_EKEY1   = 4'd4,
        S_EKEY2   = 4'd5,
        S_ESELECT = 4'd6,
        S_EBUSY   = 4'd7,
        S_IDMODE  = 4'd8,
        S_QUERY   = 4'd9
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } read_mode_t;

    localparam int BUS_BYTES_MAX = 4;
    localparam int DATA_W        = 8 * BUS_BYTES_MAX;

    localparam logic [7:0] C_KEY1   = 8'hAA;
    localparam logic [7:0] C_KEY2   = 8'h55;
    localparam logic [7:0] C_BYPASS = 8'h20;
    localparam logic [7:0] C_ERASE  = 8'h80;
    localparam logic [7:0] C_IDENT  = 8'h90;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_SECT   = 8'h30;
    localparam logic [7:0] C_CHIP   = 8'h10;
    localparam logic [7:0] C_QUERY  = 8'h98;
    localparam logic [7:0] C_RESET  = 8'hF0;

    // Byte lanes touched by one bus access of the given width code.
    function automatic logic [2:0] lane_count(input logic [1:0] bw);
        case (bw)
            2'd1:    lane_count = 3'd2;
            2'd2:    lane_count = 3'd4;
            default: lane_count = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/nor_cmd_offset.sv
module nor_cmd_offset #(
    parameter int SECT_W = 16
) (
    input  logic [SECT_W-1:0] sect_addr,
    input  logic [1:0]        bus_width,
    output logic [SECT_W-1:0] word_off
);
    // Scale the in-sector byte offset to bus words.
    always_comb begin
        case (bus_width)
            2'd1:    word_off = sect_addr >> 1;
            2'd2:    word_off = sect_addr >> 2;
            default: word_off = sect_addr;
        endcase
    end
endmodule

// File: rtl/nor_cmd_timer.sv
module nor_cmd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int              ADDR_W         = 20,
    parameter int              SECT_W         = 16,
    parameter logic [SECT_W-1:0] UNLK_OFF_A   = 'h555,
    parameter logic [SECT_W-1:0] UNLK_OFF_B   = 'h2AA,
    parameter int              SECT_ERASE_CYC = 50_000_000,
    parameter int              CHIP_ERASE_CYC = 500_000_000,
    parameter int              CNT_W          = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        bus_width,
    input  logic              read_only,
    input  logic [SECT_W-1:0] word_off,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              tmr_run,
    output seq_state_t        state,
    output read_mode_t        read_mode,
    output logic              bypass,
    output logic [7:0]        status_byte,
    output logic              prog_stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic [2:0]        prog_bytes,
    output logic              sect_erase_stb,
    output logic              chip_erase_stb,
    output logic [ADDR_W-1:0] erase_addr
);
    localparam logic [SECT_W-1:0] QRY_OFF = SECT_W'('h55);

    seq_state_t nxt_state;
    logic       nxt_byp;
    logic       do_prog, do_sect, do_chip, do_expire;
    logic [7:0] cmd_byte;
    logic       hit_a, hit_b, hit_q;

    assign cmd_byte = wr_data[7:0];
    assign hit_a    = (word_off == UNLK_OFF_A);
    assign hit_b    = (word_off == UNLK_OFF_B);
    assign hit_q    = (word_off == QRY_OFF);
    assign tmr_run  = (state == S_EBUSY);

    // Next-state decode
    always_comb begin
        nxt_state = state;
        nxt_byp   = bypass;
        do_prog   = 1'b0;
        do_sect   = 1'b0;
        do_chip   = 1'b0;
        do_expire = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        if (wr_en && cmd_byte == C_RESET && state != S_PROGRAM) begin
            nxt_state = S_IDLE;
            nxt_byp   = 1'b0;
        end else if (state == S_EBUSY) begin
            if (tmr_expired) begin
                do_expire = 1'b1;
                nxt_state = bypass ? S_DECODE : S_IDLE;
            end
        end else if (wr_en) begin
            // Fallback for every unmatched write
            nxt_state = S_IDLE;
            nxt_byp   = 1'b0;
            unique case (state)
                S_IDLE, S_EKEY1: begin
                    if (hit_q && cmd_byte == C_QUERY) begin
                        nxt_state = S_QUERY;
                        nxt_byp   = bypass;
                    end else if (hit_a && cmd_byte == C_KEY1) begin
                        nxt_state = (state == S_IDLE) ? S_KEY2 : S_EKEY2;
                        nxt_byp   = bypass;
                    end
                end
                S_KEY2, S_EKEY2: begin
                    if (hit_b && cmd_byte == C_KEY2) begin
                        nxt_state = (state == S_KEY2) ? S_DECODE : S_ESELECT;
                        nxt_byp   = bypass;
                    end
                end
                S_DECODE: begin
                    if (bypass || hit_a) begin
                        case (cmd_byte)
                            C_BYPASS: begin nxt_state = S_DECODE;  nxt_byp = 1'b1;   end
                            C_ERASE:  begin nxt_state = S_EKEY1;   nxt_byp = bypass; end
                            C_IDENT:  begin nxt_state = S_IDMODE;  nxt_byp = bypass; end
                            C_PROG:   begin nxt_state = S_PROGRAM; nxt_byp = bypass; end
                            default:  ;
                        endcase
                    end
                end
                S_PROGRAM: begin
                    do_prog   = 1'b1;
                    nxt_byp   = bypass;
                    nxt_state = bypass ? S_DECODE : S_IDLE;
                end
                S_ESELECT: begin
                    if (cmd_byte == C_SECT) begin
                        do_sect   = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(SECT_ERASE_CYC - 1);
                        nxt_state = S_EBUSY;
                        nxt_byp   = bypass;
                    end else if (cmd_byte == C_CHIP && hit_a) begin
                        do_chip   = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(CHIP_ERASE_CYC - 1);
                        nxt_state = S_EBUSY;
                        nxt_byp   = bypass;
                    end
                end
                S_IDMODE: begin
                    if (hit_q && cmd_byte == C_QUERY) begin
                        nxt_state = S_QUERY;
                        nxt_byp   = bypass;
                    end
                end
                S_QUERY, S_EBUSY: ;
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            bypass <= 1'b0;
        end else begin
            state  <= nxt_state;
            bypass <= nxt_byp;
        end
    end

    // Registered outputs toward the array and the read path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_stb       <= 1'b0;
            sect_erase_stb <= 1'b0;
            chip_erase_stb <= 1'b0;
            prog_addr      <= '0;
            prog_data      <= '0;
            prog_bytes     <= 3'd1;
            erase_addr     <= '0;
            status_byte    <= 8'h00;
        end else begin
            prog_stb       <= do_prog && !read_only;
            sect_erase_stb <= do_sect && !read_only;
            chip_erase_stb <= do_chip && !read_only;
            if (do_prog) begin
                prog_addr  <= wr_addr;
                prog_data  <= wr_data;
                prog_bytes <= lane_count(bus_width);
            end
            if (do_sect) begin
                erase_addr <= {wr_addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
            end else if (do_chip) begin
                erase_addr <= '0;
            end
            if (do_prog) begin
                status_byte <= {~wr_data[7], 7'h7F};
            end else if (do_sect || do_chip) begin
                status_byte <= 8'h00;
            end else if (do_expire) begin
                status_byte[7] <= ~status_byte[7];
            end
        end
    end

    // Read source decode
    always_comb begin
        unique case (state)
            S_IDMODE:           read_mode = RM_IDENT;
            S_QUERY:            read_mode = RM_QUERY;
            S_PROGRAM, S_EBUSY: read_mode = RM_STATUS;
            default:            read_mode = RM_ARRAY;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int                ADDR_W         = 20,
    parameter int                SECT_W         = 16,
    parameter logic [SECT_W-1:0] UNLK_OFF_A     = 'h555,
    parameter logic [SECT_W-1:0] UNLK_OFF_B     = 'h2AA,
    parameter int                SECT_ERASE_CYC = 50_000_000,
    parameter int                CHIP_ERASE_CYC = 500_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        bus_width,
    input  logic              read_only,
    output logic [3:0]        cmd_state,
    output logic [1:0]        read_mode,
    output logic              bypass_active,
    output logic [7:0]        status_byte,
    output logic              prog_stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [31:0]       prog_data,
    output logic [2:0]        prog_bytes,
    output logic              sect_erase_stb,
    output logic              chip_erase_stb,
    output logic [ADDR_W-1:0] erase_addr
);
    localparam int MAX_CYC = (CHIP_ERASE_CYC > SECT_ERASE_CYC) ? CHIP_ERASE_CYC : SECT_ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [SECT_W-1:0] word_off;
    logic              tmr_load, tmr_run, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    seq_state_t        state;
    read_mode_t        rmode;

    nor_cmd_offset #(.SECT_W(SECT_W)) u_off (
        .sect_addr (wr_addr[SECT_W-1:0]),
        .bus_width (bus_width),
        .word_off  (word_off)
    );

    nor_cmd_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    nor_cmd_fsm #(
        .ADDR_W         (ADDR_W),
        .SECT_W         (SECT_W),
        .UNLK_OFF_A     (UNLK_OFF_A),
        .UNLK_OFF_B     (UNLK_OFF_B),
        .SECT_ERASE_CYC (SECT_ERASE_CYC),
        .CHIP_ERASE_CYC (CHIP_ERASE_CYC),
        .CNT_W          (CNT_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .bus_width      (bus_width),
        .read_only      (read_only),
        .word_off       (word_off),
        .tmr_expired    (tmr_expired),
        .tmr_load       (tmr_load),
        .tmr_val        (tmr_val),
        .tmr_run        (tmr_run),
        .state          (state),
        .read_mode      (rmode),
        .bypass         (bypass_active),
        .status_byte    (status_byte),
        .prog_stb       (prog_stb),
        .prog_addr      (prog_addr),
        .prog_data      (prog_data),
        .prog_bytes     (prog_bytes),
        .sect_erase_stb (sect_erase_stb),
        .chip_erase_stb (chip_erase_stb),
        .erase_addr     (erase_addr)
    );

    assign cmd_state = state;
    assign read_mode = rmode;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
    import nor_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] cmd_byte,
    input logic       read_only,
    input logic [3:0] cmd_state,
    input logic       bypass_active,
    input logic [7:0] status_byte,
    input logic       prog_stb,
    input logic       sect_erase_stb,
    input logic       chip_erase_stb
);
    a_r13_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, sect_erase_stb, chip_erase_stb}));

    a_r12_read_only_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb || sect_erase_stb || chip_erase_stb) |-> !$past(read_only));

    a_r5_program_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_state == S_PROGRAM && wr_en && !read_only) |=> prog_stb);

    a_r5_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |-> (status_byte[6:0] == 7'h7F));

    a_r11_query_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_state == S_QUERY && wr_en) |=> (cmd_state == S_IDLE && !bypass_active));

    a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_state == S_EBUSY && wr_en && cmd_byte != C_RESET)
            |=> !(prog_stb || sect_erase_stb || chip_erase_stb));

    a_r9_reset_command: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_byte == C_RESET && cmd_state != S_PROGRAM)
            |=> (cmd_state == S_IDLE && !bypass_active));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .cmd_byte       (wr_data[7:0]),
    .read_only      (read_only),
    .cmd_state      (cmd_state),
    .bypass_active  (bypass_active),
    .status_byte    (status_byte),
    .prog_stb       (prog_stb),
    .sect_erase_stb (sect_erase_stb),
    .chip_erase_stb (chip_erase_stb)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  bus_width = 2'd0;
    logic        read_only = 1'b0;
    logic [3:0]  cmd_state;
    logic [1:0]  read_mode;
    logic        bypass_active;
    logic [7:0]  status_byte;
    logic        prog_stb, sect_erase_stb, chip_erase_stb;
    logic [19:0] prog_addr, erase_addr;
    logic [31:0] prog_data;
    logic [2:0]  prog_bytes;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nor_cmd_seq #(
        .ADDR_W(20), .SECT_W(16),
        .SECT_ERASE_CYC(40), .CHIP_ERASE_CYC(100)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bus_width(bus_width), .read_only(read_only),
        .cmd_state(cmd_state), .read_mode(read_mode),
        .bypass_active(bypass_active), .status_byte(status_byte),
        .prog_stb(prog_stb), .prog_addr(prog_addr), .prog_data(prog_data),
        .prog_bytes(prog_bytes), .sect_erase_stb(sect_erase_stb),
        .chip_erase_stb(chip_erase_stb), .erase_addr(erase_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One write cycle; called and returning at a falling edge.
    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [19:0] uoff(input logic [19:0] base, input logic [15:0] o);
        int sh;
        sh = (bus_width == 2'd1) ? 1 : (bus_width == 2'd2) ? 2 : 0;
        return base | (20'(o) << sh);
    endfunction

    task automatic unlock_cmd(input logic [19:0] base, input logic [7:0] c);
        wr(uoff(base, 16'h555), 32'hAA);
        wr(uoff(base, 16'h2AA), 32'h55);
        wr(uoff(base, 16'h555), {24'h0, c});
    endtask

    task automatic erase_prefix();
        unlock_cmd(20'h0, 8'h80);
        wr(uoff(0, 16'h555), 32'hAA);
        wr(uoff(0, 16'h2AA), 32'h55);
    endtask

    task automatic t_reset();
        check("R1", "state", 32'(cmd_state), 32'd0);
        check("R1", "mode", 32'(read_mode), 32'd0);
        check("R1", "bypass", 32'(bypass_active), 32'd0);
        check("R1", "status", 32'(status_byte), 32'h00);
        check("R1", "strobes", 32'({prog_stb, sect_erase_stb, chip_erase_stb}), 32'd0);
    endtask

    task automatic t_query_idle();
        bus_width = 2'd0;
        wr(20'h00055, 32'h98);
        check("R3", "query entry state", 32'(cmd_state), 32'd9);
        check("R13", "query mode", 32'(read_mode), 32'd2);
        wr(20'h01234, 32'h77);
        check("R11", "query exit state", 32'(cmd_state), 32'd0);
    endtask

    task automatic t_prog_byte();
        bus_width = 2'd0;
        unlock_cmd(20'h30000, 8'hA0);
        check("R2", "unlock in other sector", 32'(cmd_state), 32'd3);
        check("R13", "program mode", 32'(read_mode), 32'd3);
        wr(20'h12345, 32'h3C);
        check("R5", "prog_stb", 32'(prog_stb), 32'd1);
        check("R5", "prog_addr", 32'(prog_addr), 32'h12345);
        check("R5", "prog_data", prog_data, 32'h3C);
        check("R5", "prog_bytes", 32'(prog_bytes), 32'd1);
        check("R5", "status", 32'(status_byte), 32'hFF);
        check("R5", "state after", 32'(cmd_state), 32'd0);
        @(negedge clk);
        check("R5", "strobe one cycle", 32'(prog_stb), 32'd0);
    endtask

    task automatic t_prog_half();
        bus_width = 2'd1;
        wr(20'h00555, 32'hAA);
        check("R2", "byte offset on 2-byte bus rejected", 32'(cmd_state), 32'd0);
        unlock_cmd(20'h0, 8'hA0);
        check("R2", "2-byte unlock", 32'(cmd_state), 32'd3);
        wr(20'h00100, 32'hBEEF);
        check("R5", "half prog_bytes", 32'(prog_bytes), 32'd2);
        check("R5", "half prog_data", prog_data, 32'hBEEF);
        check("R5", "half status", 32'(status_byte), 32'h7F);
    endtask

    task automatic t_prog_word();
        bus_width = 2'd2;
        unlock_cmd(20'h0, 8'hA0);
        check("R2", "4-byte unlock", 32'(cmd_state), 32'd3);
        wr(20'h00200, 32'hCAFE0001);
        check("R5", "word prog_bytes", 32'(prog_bytes), 32'd4);
        check("R5", "word prog_data", prog_data, 32'hCAFE0001);
        check("R5", "word status", 32'(status_byte), 32'hFF);
        bus_width = 2'd0;
    endtask

    task automatic t_bad_seq();
        bus_width = 2'd0;
        wr(20'h00556, 32'hAA);
        check("R3", "wrong first address", 32'(cmd_state), 32'd0);
        wr(20'h00555, 32'hAA);
        check("R3", "first cycle ok", 32'(cmd_state), 32'd1);
        wr(20'h002AB, 32'h55);
        check("R4", "wrong second address", 32'(cmd_state), 32'd0);
        unlock_cmd(20'h0, 8'h42);
        check("R4", "unknown command", 32'(cmd_state), 32'd0);
        wr(20'h00555, 32'hAA);
        wr(20'h002AA, 32'h55);
        wr(20'h00554, 32'hA0);
        check("R4", "command at wrong address", 32'(cmd_state), 32'd0);
    endtask

    task automatic t_reset_cmd();
        wr(20'h00555, 32'hAA);
        wr(20'h00000, 32'hF0);
        check("R9", "reset from key2", 32'(cmd_state), 32'd0);
        unlock_cmd(20'h0, 8'hA0);
        wr(20'h04000, 32'hF0);
        check("R9", "F0 programmed as data", 32'(prog_stb), 32'd1);
        check("R9", "F0 data value", prog_data, 32'hF0);
        check("R9", "state after F0 program", 32'(cmd_state), 32'd0);
    endtask

    task automatic t_bypass();
        unlock_cmd(20'h0, 8'h20);
        check("R6", "bypass state", 32'(cmd_state), 32'd2);
        check("R6", "bypass flag", 32'(bypass_active), 32'd1);
        wr(20'h00777, 32'hA0);
        check("R6", "bypass command any address", 32'(cmd_state), 32'd3);
        wr(20'h08000, 32'h55);
        check("R6", "bypass prog_stb", 32'(prog_stb), 32'd1);
        check("R6", "bypass prog_addr", 32'(prog_addr), 32'h08000);
        check("R6", "return to decode", 32'(cmd_state), 32'd2);
        wr(20'h00123, 32'hA0);
        wr(20'h00124, 32'h0F);
        check("R6", "second bypass program", 32'(prog_stb), 32'd1);
        wr(20'h00999, 32'h90);
        check("R10", "ident state", 32'(cmd_state), 32'd8);
        check("R13", "ident mode", 32'(read_mode), 32'd1);
        wr(20'h00000, 32'h00);
        check("R10", "bypass exit state", 32'(cmd_state), 32'd0);
        check("R10", "bypass cleared", 32'(bypass_active), 32'd0);
    endtask

    task automatic t_autosel_query();
        unlock_cmd(20'h0, 8'h90);
        check("R10", "ident entry", 32'(cmd_state), 32'd8);
        wr(20'h00055, 32'h98);
        check("R10", "query from ident", 32'(cmd_state), 32'd9);
        wr(20'h00055, 32'h98);
        check("R11", "any write leaves query", 32'(cmd_state), 32'd0);
        unlock_cmd(20'h0, 8'h90);
        wr(20'h00100, 32'h33);
        check("R10", "other write leaves ident", 32'(cmd_state), 32'd0);
        unlock_cmd(20'h0, 8'h20);
        wr(20'h00000, 32'h90);
        wr(20'h00055, 32'h98);
        check("R10", "bypass kept in query", 32'(bypass_active), 32'd1);
        wr(20'h00010, 32'h12);
        check("R11", "query clears bypass", 32'(bypass_active), 32'd0);
        check("R11", "query to idle", 32'(cmd_state), 32'd0);
    endtask

    task automatic t_sector_erase();
        erase_prefix();
        check("R7", "erase select state", 32'(cmd_state), 32'd6);
        wr(20'h23456, 32'h30);
        check("R7", "sector strobe", 32'(sect_erase_stb), 32'd1);
        check("R7", "sector base", 32'(erase_addr), 32'h20000);
        check("R7", "erase status", 32'(status_byte), 32'h00);
        check("R8", "busy state", 32'(cmd_state), 32'd7);
        check("R13", "busy mode", 32'(read_mode), 32'd3);
        wr(20'h00555, 32'hAA);
        check("R8", "write ignored in busy", 32'(cmd_state), 32'd7);
        check("R8", "no strobe in busy", 32'({prog_stb, sect_erase_stb, chip_erase_stb}), 32'd0);
        repeat (38) @(negedge clk);
        check("R8", "busy at last cycle", 32'(cmd_state), 32'd7);
        @(negedge clk);
        check("R8", "idle after expiry", 32'(cmd_state), 32'd0);
        check("R8", "status toggled", 32'(status_byte), 32'h80);
    endtask

    task automatic t_chip_erase();
        erase_prefix();
        wr(20'h00100, 32'h10);
        check("R7", "chip erase wrong address", 32'(cmd_state), 32'd0);
        check("R7", "no chip strobe", 32'(chip_erase_stb), 32'd0);
        erase_prefix();
        wr(20'h00555, 32'h10);
        check("R7", "chip strobe", 32'(chip_erase_stb), 32'd1);
        check("R7", "chip status", 32'(status_byte), 32'h00);
        repeat (99) @(negedge clk);
        check("R8", "chip busy last cycle", 32'(cmd_state), 32'd7);
        @(negedge clk);
        check("R8", "chip idle", 32'(cmd_state), 32'd0);
        check("R8", "chip status toggled", 32'(status_byte), 32'h80);
    endtask

    task automatic t_busy_abort();
        erase_prefix();
        wr(20'h10000, 32'h30);
        wr(20'h00000, 32'hF0);
        check("R9", "abort busy", 32'(cmd_state), 32'd0);
        repeat (50) @(negedge clk);
        check("R9", "no toggle after abort", 32'(status_byte), 32'h00);
    endtask

    task automatic t_bypass_erase();
        unlock_cmd(20'h0, 8'h20);
        wr(20'h00000, 32'h80);
        wr(20'h00555, 32'hAA);
        wr(20'h002AA, 32'h55);
        wr(20'h10000, 32'h30);
        check("R7", "bypass sector strobe", 32'(sect_erase_stb), 32'd1);
        repeat (40) @(negedge clk);
        check("R8", "expiry returns to decode", 32'(cmd_state), 32'd2);
        check("R8", "bypass still set", 32'(bypass_active), 32'd1);
        wr(20'h00000, 32'hF0);
        check("R9", "F0 clears bypass", 32'(bypass_active), 32'd0);
    endtask

    task automatic t_read_only();
        read_only = 1'b1;
        unlock_cmd(20'h0, 8'hA0);
        wr(20'h00010, 32'h80);
        check("R12", "no program strobe", 32'(prog_stb), 32'd0);
        check("R12", "status still updated", 32'(status_byte), 32'h7F);
        check("R12", "state still idle", 32'(cmd_state), 32'd0);
        erase_prefix();
        wr(20'h00000, 32'h30);
        check("R12", "no erase strobe", 32'(sect_erase_stb), 32'd0);
        check("R12", "busy still entered", 32'(cmd_state), 32'd7);
        check("R12", "erase status", 32'(status_byte), 32'h00);
        wr(20'h00000, 32'hF0);
        read_only = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_query_idle();
        t_prog_byte();
        t_prog_half();
        t_prog_word();
        t_bad_seq();
        t_reset_cmd();
        t_bypass();
        t_autosel_query();
        t_sector_erase();
        t_chip_erase();
        t_busy_abort();
        t_bypass_erase();
        t_read_only();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule